// File: doc/BRIEF.md
# Dual Phase Comparator with Lock Detection

The block serves two synthesizer sections, called A and B. Each section has a digital phase/frequency comparator. It compares the rising edges of a divided reference (`fr`) with the rising edges of a divided feedback (`fp`), both sampled on the oscillator clock `clk`. The comparator drives a three-state pump control, given as a drive enable plus a level, and its polarity is set by a per-section invert input. A lock meter in each section counts how many oscillator clocks each error pulse lasts. It declares lock after three consecutive narrow pulses and drops lock on a wide one. Widths between the two limits leave the lock state alone.

A single shared monitor pin shows one of two things. It shows either the AND of both sections' lock indications, where a powered-down section counts as locked, or one of four raw divider signals picked by a two-bit select. Powering a section down returns its comparator to idle and releases the pump (high impedance). The pump currents and the loop filter sit outside this block.

The comparator state machine has four states. `PS_IDLE` means no edge is pending. `PS_UP` means `fr` arrived first. `PS_DN` means `fp` arrived first. `PS_CLR` is one clock with both pump flags set. Its transitions are:
- start-up, IDLE to UP or DN;
- coincidence, IDLE to CLR;
- close, UP or DN to CLR;
- release, CLR to IDLE;
- power-down, any state to IDLE.

The lock meter has two states, `LS_HUNT` and `LS_HELD`, with two transitions:
- acquire, HUNT to HELD on the third consecutive good width;
- drop, HELD to HUNT on a wide width or on power-down.

Top module: `pfd_lock_top`

## Requirements
- R1: While `fr` has risen and `fp` has not, `pump_up` is high, `cp_oe` is 1, and `cp_lvl` equals `fc` (1 = drive high, 0 = drive low).
- R2: While `fp` has risen and `fr` has not, `pump_dn` is high, `cp_oe` is 1, and `cp_lvl` equals the inverse of `fc`.
- R3: Rising edges of `fr` and `fp` seen in the same clock produce exactly one clock with `pump_up` and `pump_dn` both high, and `cp_oe` stays 0 (high impedance). This short pulse prevents a dead zone.
- R4: One clock after both edges have been seen, both pump flags clear and `cp_oe` returns to 0. Edges that arrive during that clearing clock are dropped.
- R5: An error pulse of width w clocks is good when w < GOOD_MAX (8). Lock rises in the clock that ends the third consecutive good pulse and not earlier. A coincident comparison counts as width 0.
- R6: A pulse of width w >= LOSE_MIN (16) drops lock in the clock that ends it and restarts the good count.
- R7: A width from 8 to 15 leaves the lock state unchanged and restarts the good count.
- R8: When `pd` of a section is high, the section's comparator returns to idle, its pump flags and `cp_oe` are 0, and its lock indication is cleared.
- R9: With `lds` = 0, `mon_pin` = AND over sections of (`sec_lock` OR `pd`).
- R10: With `lds` = 1, `mon_pin` follows a raw input picked by `tsel`. Bit 0 picks the section (0 = A, 1 = B) and bit 1 picks the signal (0 = `fr`, 1 = `fp`).
- R11: After reset, `sec_lock` is 0, the good count is 0 and `cp_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | oscillator clock |
| rst_n | input | 1 | active-low reset |
| fr | input | 2 | divided reference, one bit per section |
| fp | input | 2 | divided feedback, one bit per section |
| fc | input | 2 | pump polarity per section |
| pd | input | 2 | power-down per section |
| lds | input | 1 | 1 = monitor signal on pin, 0 = combined lock |
| tsel | input | 2 | monitor select |
| pump_up | output | 2 | reference-leads flag |
| pump_dn | output | 2 | feedback-leads flag |
| cp_oe | output | 2 | pump drive enable (0 = high impedance) |
| cp_lvl | output | 2 | pump drive level when enabled |
| sec_lock | output | 2 | per-section lock indication |
| mon_pin | output | 1 | shared monitor output |

## Verification
The comparison-closing clock is where two functions coincide: the comparator enters its clearing state in the same cycle that the lock meter judges the finished pulse width. The bench drives lead/lag pairs with offsets swept from 0 to 20 clocks in both directions on each section. It checks the pump direction inside every pulse, and checks lock against an arithmetic model of the good/wide/band rules after each pulse. Coincident edges are included because they are both the dead-zone case and a width-0 good pulse. Power-down is applied while an edge is pending, which tests the case where the idle forcing and the lock clearing land in one cycle.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_UP   = 2'd1,
        PS_DN   = 2'd2,
        PS_CLR  = 2'd3
    } pfd_state_e;

    typedef enum logic {
        LS_HUNT = 1'b0,
        LS_HELD = 1'b1
    } lock_state_e;
endpackage

// File: rtl/pfd_core.sv
module pfd_core
    import pfd_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pd,
    input  logic             fr,
    input  logic             fp,
    input  logic             fc,
    output logic             pump_up,
    output logic             pump_dn,
    output logic             cp_oe,
    output logic             cp_lvl,
    output logic             done,
    output logic [CNT_W-1:0] width
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    pfd_state_e        state_q, state_d;
    logic              fr_q, fp_q;
    logic              fr_e, fp_e;
    logic [CNT_W-1:0]  cnt_q;

    assign fr_e = fr & ~fr_q;
    assign fp_e = fp & ~fp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q <= 1'b0;
            fp_q <= 1'b0;
        end else begin
            fr_q <= fr;
            fp_q <= fp;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_IDLE: begin
                if (fr_e && fp_e)  state_d = PS_CLR;
                else if (fr_e)     state_d = PS_UP;
                else if (fp_e)     state_d = PS_DN;
            end
            PS_UP:   if (fp_e) state_d = PS_CLR;
            PS_DN:   if (fr_e) state_d = PS_CLR;
            PS_CLR:  state_d = PS_IDLE;
            default: state_d = PS_IDLE;
        endcase
        if (pd) state_d = PS_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_IDLE;
        else        state_q <= state_d;
    end

    // pulse width counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if ((state_q == PS_UP || state_q == PS_DN) && !pd) begin
            if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        end else begin
            cnt_q <= '0;
        end
    end

    // outputs
    always_comb begin
        pump_up = 1'b0;
        pump_dn = 1'b0;
        unique case (state_q)
            PS_IDLE: ;
            PS_UP:   pump_up = 1'b1;
            PS_DN:   pump_dn = 1'b1;
            PS_CLR: begin
                pump_up = 1'b1;
                pump_dn = 1'b1;
            end
            default: ;
        endcase
        cp_oe  = pump_up ^ pump_dn;
        cp_lvl = cp_oe & (fc ? pump_up : pump_dn);
        done   = (state_q != PS_CLR) && (state_d == PS_CLR);
        if (state_q == PS_IDLE)     width = '0;
        else if (cnt_q == CNT_MAX)  width = CNT_MAX;
        else                        width = cnt_q + 1'b1;
    end
endmodule

// File: rtl/lock_meter.sv
module lock_meter
    import pfd_pkg::*;
#(
    parameter int CNT_W    = 6,
    parameter int GOOD_MAX = 8,
    parameter int LOSE_MIN = 16,
    parameter int NEED     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pd,
    input  logic             done,
    input  logic [CNT_W-1:0] width,
    output logic             locked
);
    localparam int GW = $clog2(NEED + 1);
    localparam logic [GW-1:0]    LAST  = GW'(NEED - 1);
    localparam logic [CNT_W-1:0] W_OK  = CNT_W'(GOOD_MAX);
    localparam logic [CNT_W-1:0] W_BAD = CNT_W'(LOSE_MIN);

    lock_state_e   state_q, state_d;
    logic [GW-1:0] good_q, good_d;
    logic          is_good, is_wide;

    assign is_good = width < W_OK;
    assign is_wide = width >= W_BAD;

    always_comb begin
        state_d = state_q;
        good_d  = good_q;
        unique case (state_q)
            LS_HUNT: begin
                if (done) begin
                    if (is_good) begin
                        if (good_q == LAST) begin
                            state_d = LS_HELD;
                            good_d  = '0;
                        end else begin
                            good_d = good_q + 1'b1;
                        end
                    end else begin
                        good_d = '0;
                    end
                end
            end
            LS_HELD: begin
                if (done && is_wide) begin
                    state_d = LS_HUNT;
                    good_d  = '0;
                end
            end
            default: state_d = LS_HUNT;
        endcase
        if (pd) begin
            state_d = LS_HUNT;
            good_d  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LS_HUNT;
            good_q  <= '0;
        end else begin
            state_q <= state_d;
            good_q  <= good_d;
        end
    end

    always_comb locked = (state_q == LS_HELD);
endmodule

// File: rtl/pin_mux.sv
module pin_mux #(
    parameter int NSEC = 2
) (
    input  logic [NSEC-1:0] fr,
    input  logic [NSEC-1:0] fp,
    input  logic [NSEC-1:0] sec_lock,
    input  logic [NSEC-1:0] pd,
    input  logic            lds,
    input  logic [1:0]      tsel,
    output logic            mon_pin
);
    logic combined;
    logic monitor;

    always_comb begin
        combined = &(sec_lock | pd);
        monitor  = tsel[1] ? fp[tsel[0]] : fr[tsel[0]];
        mon_pin  = lds ? monitor : combined;
    end
endmodule

// File: rtl/pfd_lock_top.sv
module pfd_lock_top #(
    parameter int GOOD_MAX = 8,
    parameter int LOSE_MIN = 16,
    parameter int NEED     = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] fr,
    input  logic [1:0] fp,
    input  logic [1:0] fc,
    input  logic [1:0] pd,
    input  logic       lds,
    input  logic [1:0] tsel,
    output logic [1:0] pump_up,
    output logic [1:0] pump_dn,
    output logic [1:0] cp_oe,
    output logic [1:0] cp_lvl,
    output logic [1:0] sec_lock,
    output logic       mon_pin
);
    localparam int NSEC  = 2;
    localparam int CNT_W = $clog2(LOSE_MIN + 1) + 1;

    logic [NSEC-1:0] done;
    logic [CNT_W-1:0] width [NSEC];

    for (genvar s = 0; s < NSEC; s++) begin : g_sec
        pfd_core #(.CNT_W(CNT_W)) u_pfd (
            .clk     (clk),
            .rst_n   (rst_n),
            .pd      (pd[s]),
            .fr      (fr[s]),
            .fp      (fp[s]),
            .fc      (fc[s]),
            .pump_up (pump_up[s]),
            .pump_dn (pump_dn[s]),
            .cp_oe   (cp_oe[s]),
            .cp_lvl  (cp_lvl[s]),
            .done    (done[s]),
            .width   (width[s])
        );

        lock_meter #(
            .CNT_W    (CNT_W),
            .GOOD_MAX (GOOD_MAX),
            .LOSE_MIN (LOSE_MIN),
            .NEED     (NEED)
        ) u_lock (
            .clk    (clk),
            .rst_n  (rst_n),
            .pd     (pd[s]),
            .done   (done[s]),
            .width  (width[s]),
            .locked (sec_lock[s])
        );
    end

    pin_mux #(.NSEC(NSEC)) u_mux (
        .fr       (fr),
        .fp       (fp),
        .sec_lock (sec_lock),
        .pd       (pd),
        .lds      (lds),
        .tsel     (tsel),
        .mon_pin  (mon_pin)
    );
endmodule

// File: rtl/pfd_lock_chk.sv
module pfd_lock_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] pd,
    input logic       lds,
    input logic [1:0] pump_up,
    input logic [1:0] pump_dn,
    input logic [1:0] sec_lock,
    input logic       mon_pin
);
    for (genvar i = 0; i < 2; i++) begin : g_chk
        AST_UP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (pump_up[i] && !pump_dn[i] && !pd[i]) |=> pump_up[i]); // R1
        AST_DN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (pump_dn[i] && !pump_up[i] && !pd[i]) |=> pump_dn[i]); // R2
        AST_CLR_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
            (pump_up[i] && pump_dn[i]) |=> !(pump_up[i] && pump_dn[i])); // R4
        AST_LOCK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(sec_lock[i]) |-> (pump_up[i] && pump_dn[i])); // R5
        AST_LOCK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(sec_lock[i]) |-> ((pump_up[i] && pump_dn[i]) || $past(pd[i]))); // R6
        AST_PD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            pd[i] |=> (!pump_up[i] && !pump_dn[i])); // R8
        AST_PIN_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
            (!lds && !pd[i] && !sec_lock[i]) |-> !mon_pin); // R9
    end
endmodule

bind pfd_lock_top pfd_lock_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pd       (pd),
    .lds      (lds),
    .pump_up  (pump_up),
    .pump_dn  (pump_dn),
    .sec_lock (sec_lock),
    .mon_pin  (mon_pin)
);

// File: tb/pfd_lock_top_tb.sv
module pfd_lock_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] fr = '0, fp = '0, fc = '0, pd = '0, tsel = '0;
    logic       lds = 1'b0;
    logic [1:0] pump_up, pump_dn, cp_oe, cp_lvl, sec_lock;
    logic       mon_pin;

    int total = 0;
    int bad   = 0;
    bit lk [2];
    int good [2];
    bit finished = 0;

    always #5 clk = ~clk;

    pfd_lock_top u_dut (
        .clk(clk), .rst_n(rst_n), .fr(fr), .fp(fp), .fc(fc), .pd(pd),
        .lds(lds), .tsel(tsel), .pump_up(pump_up), .pump_dn(pump_dn),
        .cp_oe(cp_oe), .cp_lvl(cp_lvl), .sec_lock(sec_lock), .mon_pin(mon_pin)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // lock rule model: good < 8, wide >= 16, band keeps state
    task automatic model_update(input int s, input int w);
        if (lk[s]) begin
            if (w >= 16) begin lk[s] = 0; good[s] = 0; end
        end else if (w < 8) begin
            good[s]++;
            if (good[s] == 3) begin lk[s] = 1; good[s] = 0; end
        end else begin
            good[s] = 0;
        end
    endtask

    // mode 0: fr leads, 1: fp leads, 2: coincident edges
    task automatic compare(input int s, input int mode, input int d);
        if (mode == 2) begin
            @(negedge clk); fr[s] = 1'b1; fp[s] = 1'b1;
            @(negedge clk);
            check("R3 both flags", int'(pump_up[s] & pump_dn[s]), 1);
            check("R3 pump hi-z", int'(cp_oe[s]), 0);
            @(negedge clk);
            check("R4 release", int'({pump_up[s], pump_dn[s], cp_oe[s]}), 0);
            model_update(s, 0);
        end else begin
            @(negedge clk);
            if (mode == 0) fr[s] = 1'b1; else fp[s] = 1'b1;
            @(negedge clk);
            if (mode == 0) begin
                check("R1 up drive", int'(cp_oe[s] & pump_up[s]), 1);
                check("R1 up level", int'(cp_lvl[s]), int'(fc[s]));
            end else begin
                check("R2 dn drive", int'(cp_oe[s] & pump_dn[s]), 1);
                check("R2 dn level", int'(cp_lvl[s]), int'(!fc[s]));
            end
            repeat (d - 1) @(negedge clk);
            if (mode == 0) fp[s] = 1'b1; else fr[s] = 1'b1;
            @(negedge clk);
            @(negedge clk);
            check("R4 closed", int'(cp_oe[s]), 0);
            model_update(s, d);
        end
        repeat (2) @(negedge clk);
        fr[s] = 1'b0; fp[s] = 1'b0;
        repeat (2) @(negedge clk);
        check("R5 R6 R7 lock", int'(sec_lock[s]), int'(lk[s]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        fc = 2'b11;
        pd = 2'b10;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11 lock", int'(sec_lock), 0);
        check("R11 oe", int'(cp_oe), 0);
        check("R9 pin after reset", int'(mon_pin), 0);

        // R5: two good pulses, no lock yet; third locks
        compare(0, 0, 3);
        compare(0, 1, 3);
        check("R5 not yet", int'(sec_lock[0]), 0);
        compare(0, 2, 0);
        check("R5 locked", int'(sec_lock[0]), 1);
        check("R9 B powered down", int'(mon_pin), 1);
        @(negedge clk); pd[1] = 1'b0;
        @(negedge clk);
        check("R9 B unlocked", int'(mon_pin), 0);

        // polarity swap
        fc[0] = 1'b0;
        compare(0, 0, 2);
        compare(0, 1, 2);
        // R7 band keeps lock
        compare(0, 0, 10);
        check("R7 hold", int'(sec_lock[0]), 1);
        // R6 wide drops lock
        compare(0, 1, 20);
        check("R6 drop", int'(sec_lock[0]), 0);
        // R7 band restarts good count
        compare(0, 0, 1);
        compare(0, 0, 1);
        compare(0, 1, 12);
        compare(0, 0, 1);
        compare(0, 0, 1);
        check("R7 count restarted", int'(sec_lock[0]), 0);
        compare(0, 2, 0);
        check("R7 relock", int'(sec_lock[0]), 1);

        // sweep widths on both sections, both directions, both polarities
        for (int s = 0; s < 2; s++) begin
            for (int p = 0; p < 2; p++) begin
                fc[s] = p[0];
                for (int d = 1; d <= 20; d++) begin
                    compare(s, 0, d);
                    compare(s, 1, d);
                end
                compare(s, 2, 0);
            end
        end

        // R8 power-down with an edge pending
        @(negedge clk);
        fr[0] = 1'b1;
        @(negedge clk);
        pd = 2'b11;
        lk[0] = 0; good[0] = 0; lk[1] = 0; good[1] = 0;
        @(negedge clk);
        check("R8 flags", int'({pump_up[0], pump_dn[0]}), 0);
        check("R8 oe", int'(cp_oe[0]), 0);
        check("R8 lock cleared", int'(sec_lock), 0);
        check("R9 all down", int'(mon_pin), 1);
        fp[0] = 1'b1;
        @(negedge clk);
        check("R8 stays idle", int'({pump_up[0], pump_dn[0]}), 0);

        // R10 monitor select sweep
        lds = 1'b1;
        for (int pat = 0; pat < 16; pat++) begin
            for (int ts = 0; ts < 4; ts++) begin
                @(negedge clk);
                {fp, fr} = pat[3:0];
                tsel = ts[1:0];
                #1;
                check("R10 monitor", int'(mon_pin),
                      ts[1] ? int'(pat[2 + ts[0]]) : int'(pat[ts[0]]));
            end
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule